// File: doc/BRIEF.md
# Rounding-Based Approximate Multiplier

This block multiplies two W-bit operands approximately, trading a bounded error for a datapath with no partial-product array. Each operand magnitude is rounded to the nearest power of two: the leading one is found and the value is rounded up when the bit just below it is set. The product is then formed as `Ra*B + Rb*A - Ra*Rb`, which drops the cross term `(Ra-A)*(Rb-B)`. Every product term is a left shift, and two parallel-prefix additions combine the terms. A per-transaction mode selects unsigned operands, or two's-complement operands with either exact negation or inversion-only negation.

Operands enter and products leave over valid/ready handshakes, with one register stage between them. A transfer happens on a rising edge where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in the same cycle. A product held under back-pressure keeps its value until it is taken.

Top module: `rba_approx_mult`

## Requirements
- R1: In unsigned mode (`in_mode` = 2'b10), each operand `x` has leading-one position `k`, and its rounded value is `2^(k+1)` when bit `k-1` of `x` is 1 (with `k` ≥ 1), otherwise `2^k`. The output equals `Ra*B + Rb*A - Ra*Rb` as an unsigned 2W-bit value.
- R2: When both operands are powers of two, the output equals the exact product (for example 64 × 4 = 256 in unsigned mode).
- R3: In signed exact mode (`in_mode` = 2'b00), each operand is two's complement with its MSB as the sign. The magnitude is the exact absolute value, and the most negative value maps to magnitude 2^(W-1). The R1 formula is applied to the magnitudes. When exactly one operand is negative, the result is negated in two's complement.
- R4: In signed approximate mode (`in_mode` = 2'b01), negative operands and negative results are negated by bit inversion alone, without adding one. For example, −3 × 5 gives 16'hFFF5, and −1 becomes magnitude 0.
- R5: When either operand magnitude is zero, the output is exactly zero in every mode.
- R6: The worst-case rounding pair 96 × 96 in unsigned mode gives 8192, which is about 11.1% below the exact product.
- R7: An operand pair accepted at one rising edge appears on `out_prod`, with `out_valid` high, after that same edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` hold their values, and no new operand pair is accepted.
- R9: Mode 2'b11 behaves identically to mode 2'b10.
- R10: In either signed mode, two nonzero operands of the same sign give a result with a clear MSB. In signed exact mode, two nonzero operands of opposite sign give a result with a set MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_mode | input | 2 | 00 signed exact, 01 signed approximate, 10 or 11 unsigned |
| out_valid | output | 1 | Product register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_prod | output | 2W | Approximate product |

## Verification
Everything between the input ports and the product register is combinational. A wrong rounding decision, shift amount, carry or sign therefore shows on `out_prod` in the cycle right after the operands are accepted. Sweeps in every mode cover all leading-one positions and both rounding directions. An error in the handshake state shows the same cycle as a product that is duplicated, lost or changed while stalled.

// File: rtl/rba_pkg.sv
package rba_pkg;
  typedef enum logic [1:0] {
    MODE_SGN_EXACT  = 2'b00,
    MODE_SGN_APPROX = 2'b01,
    MODE_UNS        = 2'b10,
    MODE_UNS_ALT    = 2'b11
  } rba_mode_e;
endpackage

// File: rtl/rba_operand_prep.sv
// Sign detection and magnitude generation for one operand.
module rba_operand_prep
  import rba_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  input  rba_mode_e    mode,
  output logic [W-1:0] mag,
  output logic         neg
);
  logic uns_mode;
  logic approx_neg;

  assign uns_mode   = mode[1];
  assign approx_neg = mode[0];

  always_comb begin
    mag = raw;
    neg = 1'b0;
    if (!uns_mode && raw[W-1]) begin
      neg = 1'b1;
      // inversion alone in approximate mode; the most negative value maps to 2^(W-1)
      mag = approx_neg ? ~raw : (~raw + W'(1));
    end
  end
endmodule

// File: rtl/rba_pow2_round.sv
// Rounds a magnitude to the nearest power of two and returns its exponent.
module rba_pow2_round #(
  parameter int W  = 8,
  parameter int EW = $clog2(W + 1)
) (
  input  logic [W-1:0]  mag,
  output logic [EW-1:0] expo,
  output logic          nz
);
  logic [EW-1:0] lead;
  logic          up;

  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) lead = EW'(i);
    end
    up = 1'b0;
    if (lead != '0) up = mag[lead - EW'(1)];
    expo = lead + EW'(up);
    nz   = |mag;
  end
endmodule

// File: rtl/rba_ks_adder.sv
// Parallel-prefix (Kogge-Stone) adder with carry input.
module rba_ks_adder #(
  parameter int N = 18,
  parameter int L = $clog2(N)
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum
);
  logic [N-1:0] g0, p0;
  logic [N-1:0] gp [0:L];
  logic [N-1:0] pp [0:L];
  logic [N-1:0] carry;

  assign g0 = a & b;
  assign p0 = a ^ b;

  always_comb begin
    gp[0] = g0;
    pp[0] = p0;
    for (int lv = 0; lv < L; lv++) begin
      for (int i = 0; i < N; i++) begin
        if (i >= (1 << lv)) begin
          gp[lv+1][i] = gp[lv][i] | (pp[lv][i] & gp[lv][i - (1 << lv)]);
          pp[lv+1][i] = pp[lv][i] & pp[lv][i - (1 << lv)];
        end else begin
          gp[lv+1][i] = gp[lv][i];
          pp[lv+1][i] = pp[lv][i];
        end
      end
    end
    carry[0] = cin;
    for (int i = 1; i < N; i++) begin
      carry[i] = gp[L][i-1] | (pp[L][i-1] & cin);
    end
  end

  assign sum = p0 ^ carry;
endmodule

// File: rtl/rba_approx_mult.sv
module rba_approx_mult
  import rba_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [1:0]     in_mode,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod
);
  localparam int EW = $clog2(W + 1);
  localparam int PW = 2 * W;
  localparam int AW = PW + 2;

  rba_mode_e mode;
  assign mode = rba_mode_e'(in_mode);

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_a, neg_b;
  logic [EW-1:0] exp_a, exp_b;
  logic          nz_a, nz_b;

  rba_operand_prep #(.W(W)) u_prep_a (.raw(in_a), .mode(mode), .mag(mag_a), .neg(neg_a));
  rba_operand_prep #(.W(W)) u_prep_b (.raw(in_b), .mode(mode), .mag(mag_b), .neg(neg_b));

  rba_pow2_round #(.W(W), .EW(EW)) u_rnd_a (.mag(mag_a), .expo(exp_a), .nz(nz_a));
  rba_pow2_round #(.W(W), .EW(EW)) u_rnd_b (.mag(mag_b), .expo(exp_b), .nz(nz_b));

  // Three shifted terms: Ra*B, Rb*A, Ra*Rb
  logic [AW-1:0] term_rb_a, term_ra_b, term_rr;
  logic [EW:0]   exp_sum;

  assign exp_sum   = {1'b0, exp_a} + {1'b0, exp_b};
  assign term_ra_b = {{(AW-W){1'b0}}, mag_b} << exp_a;
  assign term_rb_a = {{(AW-W){1'b0}}, mag_a} << exp_b;
  assign term_rr   = {{(AW-1){1'b0}}, 1'b1} << exp_sum;

  logic [AW-1:0] sum_cross, diff;

  rba_ks_adder #(.N(AW)) u_add (.a(term_ra_b), .b(term_rb_a), .cin(1'b0), .sum(sum_cross));
  rba_ks_adder #(.N(AW)) u_sub (.a(sum_cross), .b(~term_rr), .cin(1'b1), .sum(diff));

  // Magnitude with zero forcing and clamp to the output range
  logic [PW-1:0] mag_res;
  always_comb begin
    if (!(nz_a && nz_b))             mag_res = '0;
    else if (diff[AW-1:PW] != '0)    mag_res = '1;
    else                             mag_res = diff[PW-1:0];
  end

  // Output sign application; unsigned mode never flags a negative operand
  logic          res_neg;
  logic [PW-1:0] res;
  assign res_neg = (neg_a ^ neg_b) && (mag_res != '0);
  always_comb begin
    if (!res_neg)                 res = mag_res;
    else if (mode == MODE_SGN_APPROX) res = ~mag_res;
    else                          res = ~mag_res + PW'(1);
  end

  // Single-entry output stage
  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_prod  <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_a == '0 || in_b == '0) |=> out_prod == '0); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod)); // R8
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R7
  AST_SAME_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_mode[1] && in_a != '0 && in_b != '0 && (in_a[W-1] == in_b[W-1])
    |=> !out_prod[PW-1]); // R10
  AST_OPP_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == 2'b00 && in_a != '0 && in_b != '0 && (in_a[W-1] != in_b[W-1])
    |=> out_prod[PW-1]); // R10
endmodule

// File: tb/rba_approx_mult_test.sv
module rba_approx_mult_test;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [15:0]   out_prod;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rba_approx_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  function automatic int rnd(int x);
    int k = 0;
    if (x == 0) return 0;
    for (int i = 0; i < 16; i++) if (x[i]) k = i;
    if (k > 0 && x[k-1]) return 1 << (k + 1);
    return 1 << k;
  endfunction

  function automatic int model(int a, int b, int mode);
    int ma, mb, m;
    bit na = 0, nb = 0;
    ma = a; mb = b;
    if (mode < 2) begin
      if (a >= 128) begin na = 1; ma = (mode == 1) ? 255 - a : 256 - a; end
      if (b >= 128) begin nb = 1; mb = (mode == 1) ? 255 - b : 256 - b; end
    end
    if (ma == 0 || mb == 0) return 0;
    m = rnd(ma) * mb + rnd(mb) * ma - rnd(ma) * rnd(mb);
    if (m > 65535) m = 65535;
    if ((na ^ nb) && m != 0) m = (mode == 1) ? 65535 - m : 65536 - m;
    return m;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(int a, int b, int mode, string req);
    @(negedge clk);
    in_a = W'(a); in_b = W'(b); in_mode = 2'(mode); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {15'd0, out_valid}, 1);
    check(req, int'(out_prod), model(a, b, mode));
  endtask

  task automatic t_reset();
    check("R7 reset valid", {31'd0, out_valid}, 0);
    check("R7 reset ready", {31'd0, in_ready}, 1);
  endtask

  task automatic t_directed();
    @(negedge clk); in_a = 8'd96; in_b = 8'd96; in_mode = 2'b10; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R6 worst case", int'(out_prod), 8192);
    run_op(64, 4, 2, "R2 power of two");
    check("R2 exact", int'(out_prod), 256);
    run_op(253, 5, 0, "R3 -3x5 exact");
    check("R3 -3x5", int'(out_prod), 16'hFFF0);
    run_op(128, 128, 0, "R3 most negative");
    check("R3 -128x-128", int'(out_prod), 16'h4000);
    run_op(253, 5, 1, "R4 -3x5 approx");
    check("R4 -3x5", int'(out_prod), 16'hFFF5);
    run_op(255, 77, 1, "R4 minus one");
    check("R4 -1 gives zero", int'(out_prod), 0);
    run_op(0, 200, 0, "R5 zero a");
    run_op(131, 0, 1, "R5 zero b");
    run_op(0, 0, 2, "R5 both zero");
    check("R5 zero", int'(out_prod), 0);
    run_op(255, 255, 2, "R1 max unsigned");
    check("R1 255x255", int'(out_prod), 65024);
    run_op(200, 77, 3, "R9 alt unsigned");
    check("R9 mode3", int'(out_prod), model(200, 77, 2));
    run_op(129, 3, 0, "R10 opposite sign");
    check("R10 msb set", {31'd0, out_prod[15]}, 1);
    run_op(129, 130, 1, "R10 same sign");
    check("R10 msb clear", {31'd0, out_prod[15]}, 0);
  endtask

  task automatic t_sweep(int mode, string req);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        run_op(a, b, mode, req);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    in_a = 8'd100; in_b = 8'd23; in_mode = 2'b10; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_a = 8'd45; in_b = 8'd201;
    for (int i = 0; i < 4; i++) begin
      check("R8 stall valid", {31'd0, out_valid}, 1);
      check("R8 stall ready", {31'd0, in_ready}, 0);
      check("R8 stall data", int'(out_prod), model(100, 23, 2));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next after release", int'(out_prod), model(45, 201, 2));
    check("R7 valid after release", {31'd0, out_valid}, 1);
    @(negedge clk);
    check("R7 drained", {31'd0, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_backpressure();
    t_sweep(2, "R1 unsigned sweep");
    t_sweep(0, "R3 signed exact sweep");
    t_sweep(1, "R4 signed approx sweep");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule